// File: doc/BRIEF.md
# Clock Loss Monitor with Automatic Mode Fallback

This block watches two slow clocks, an external reference and an oscillator, from a free-running local sampling clock. Each watched clock passes through a two-flop synchronizer. Its rising edges are then counted over a fixed window of sampling cycles. When a clock that the current mode depends on delivers too few edges in a window, the block latches a sticky loss flag. It then raises either an interrupt or a reset request.

The block also carries the clock-source mode registers. A mode write first updates the requested field, and the current-mode field follows one cycle later. A detected loss can override this with a forced fallback. In the external-reference locked mode, a lost reference drops to self-clocked mode and a lost oscillator drops to external bypass. In external bypass, a lost reference drops to self-clocked mode. A forced fallback rewrites both fields in the same cycle.

A detection-disable input stops all monitoring. A reference-good status reports whether the reference is both watched and fast enough.

Top module: `clkloss_guard`

## Requirements
- R1: After reset, both mode fields read 00 with the internal-loop bit 0, and loss_flag, lock_lost, rst_req and irq are 0. ref_good is 0 while mon_disable is 0.
- R2: Each window is WIN_LEN sampling cycles long and is counted from reset. At the end of a window, loss_flag sets if a watched clock showed fewer than MIN_EDGES synchronized rising edges in that window. The watched clocks depend on the current mode, with mode codes 00 off, 01 self-clocked, 10 external bypass and 11 locked loop. Off watches neither clock. Self-clocked watches the oscillator only. External bypass watches the reference only. Locked loop with the internal bit 0 (external) watches both clocks. Locked loop with the internal bit 1 watches the oscillator only.
- R3: In locked-external mode, a reference loss forces both mode fields to 01. An oscillator loss without a reference loss forces both fields to 10. A forced fallback clears the internal bit in both fields.
- R4: In external bypass, a reference loss forces both mode fields to 01. On entry to self-clocked mode from off or from external bypass, the oscillator is not watched until osc_stable is 1.
- R5: loss_flag stays set until it is acknowledged or reset. The acknowledgment is a stat_rd pulse while the flag is set, followed by a flag_wr1 pulse, with loc_rst_en 0. A flag_wr1 without a prior read leaves the flag set. lock_lost clears by the same sequence.
- R6: With loc_rst_en 1, each loss raises rst_req for exactly one cycle. irq stays 0, and the acknowledgment sequence leaves loss_flag set.
- R7: A loss detected in mode 11 (either internal bit) also sets lock_lost. With lol_rst_en 1 and loc_rst_en 0, such a loss raises rst_req and irq stays 0. Otherwise irq equals loss_flag while loc_rst_en is 0.
- R8: ref_good is 1 only while mon_disable is 1, or while the reference is watched and its last completed window had at least MIN_EDGES edges.
- R9: While mon_disable is 1, loss_flag never sets, no fallback occurs and ref_good is 1.
- R10: A mode_wr pulse loads mode_wdata and mode_wint into the requested field at the next edge. The current-mode field takes the same value one edge later, unless a forced fallback intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | 1 | Watched external reference clock |
| osc_clk_in | input | 1 | Watched oscillator clock |
| mon_disable | input | 1 | Suppresses all loss detection |
| osc_stable | input | 1 | Oscillator output has settled |
| mode_wr | input | 1 | Write strobe for the requested mode |
| mode_wdata | input | 2 | Requested mode code |
| mode_wint | input | 1 | Internal-loop select for mode 11 |
| stat_rd | input | 1 | Status read strobe (arms acknowledge) |
| flag_wr1 | input | 1 | Write-1 strobe to the loss flag |
| loc_rst_en | input | 1 | Clock loss requests reset instead of interrupt |
| lol_rst_en | input | 1 | Lock loss requests reset |
| mode_req | output | 2 | Requested mode field |
| mode_req_int | output | 1 | Requested internal-loop bit |
| mode_cur | output | 2 | Current mode field |
| mode_cur_int | output | 1 | Current internal-loop bit |
| ref_good | output | 1 | Reference watched and fast enough |
| loss_flag | output | 1 | Sticky clock-loss flag |
| lock_lost | output | 1 | Sticky loss-of-lock flag |
| irq | output | 1 | Loss interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that the watched clocks are much slower than the sampling clock, so at most one forced fallback happens per window and rst_req can never repeat on consecutive cycles. They also assume that mode writes are not issued back to back. Under that assumption, any change of the requested field that did not follow a write can be attributed to a fallback. The stimulus drives both watched clocks from the sampling-clock falling edge, at four and eight sampling cycles per period. It writes the mode once per scenario and then sweeps every mode, every pattern of stopped clocks, both disable settings and all four reset-enable combinations.

// File: rtl/clkloss_guard.sv
module clkloss_guard #(
  parameter int WIN_LEN   = 64,
  parameter int MIN_EDGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk_in,
  input  logic       osc_clk_in,
  input  logic       mon_disable,
  input  logic       osc_stable,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       mode_wint,
  input  logic       stat_rd,
  input  logic       flag_wr1,
  input  logic       loc_rst_en,
  input  logic       lol_rst_en,
  output logic [1:0] mode_req,
  output logic       mode_req_int,
  output logic [1:0] mode_cur,
  output logic       mode_cur_int,
  output logic       ref_good,
  output logic       loss_flag,
  output logic       lock_lost,
  output logic       irq,
  output logic       rst_req
);
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [EW-1:0] EDGE_MIN = EW'(MIN_EDGES);

  localparam logic [1:0] M_OFF = 2'b00;
  localparam logic [1:0] M_SCM = 2'b01;
  localparam logic [1:0] M_BYP = 2'b10;
  localparam logic [1:0] M_LCK = 2'b11;

  logic [2:0]    ref_s, osc_s;
  logic [WW-1:0] win_q;
  logic [EW-1:0] ref_cnt, osc_cnt;
  logic          ref_ok_q, osc_wait_q, arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_s <= '0;
      osc_s <= '0;
    end else begin
      ref_s <= {ref_s[1:0], ref_clk_in};
      osc_s <= {osc_s[1:0], osc_clk_in};
    end
  end

  wire ref_rise = ref_s[1] & ~ref_s[2];
  wire osc_rise = osc_s[1] & ~osc_s[2];
  wire win_end  = (win_q == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       win_q <= '0;
    else if (win_end) win_q <= '0;
    else              win_q <= win_q + WW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      osc_cnt <= '0;
    end else if (win_end) begin
      ref_cnt <= '0;
      osc_cnt <= '0;
    end else begin
      if (ref_rise && ref_cnt != EDGE_MIN) ref_cnt <= ref_cnt + EW'(1);
      if (osc_rise && osc_cnt != EDGE_MIN) osc_cnt <= osc_cnt + EW'(1);
    end
  end

  wire ref_short = ref_cnt < EDGE_MIN;
  wire osc_short = osc_cnt < EDGE_MIN;
  wire in_lock   = (mode_cur == M_LCK);
  wire lock_ext  = in_lock & ~mode_cur_int;
  wire ref_mon   = (mode_cur == M_BYP) | lock_ext;
  wire osc_mon   = ((mode_cur == M_SCM) & ~osc_wait_q) | in_lock;

  wire ref_loss  = win_end & ~mon_disable & ref_mon & ref_short;
  wire osc_loss  = win_end & ~mon_disable & osc_mon & osc_short;
  wire loss_evt  = ref_loss | osc_loss;

  wire to_scm    = ref_loss & (lock_ext | (mode_cur == M_BYP));
  wire to_byp    = osc_loss & lock_ext & ~ref_loss;

  logic [1:0] cur_d;
  logic       cur_int_d;
  always_comb begin
    if (to_scm)      begin cur_d = M_SCM;    cur_int_d = 1'b0;         end
    else if (to_byp) begin cur_d = M_BYP;    cur_int_d = 1'b0;         end
    else             begin cur_d = mode_req; cur_int_d = mode_req_int; end
  end

  wire scm_entry = (cur_d == M_SCM) & ((mode_cur == M_OFF) | (mode_cur == M_BYP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_req     <= M_OFF;
      mode_req_int <= 1'b0;
      mode_cur     <= M_OFF;
      mode_cur_int <= 1'b0;
    end else begin
      mode_cur     <= cur_d;
      mode_cur_int <= cur_int_d;
      if (to_scm || to_byp) begin
        mode_req     <= cur_d;
        mode_req_int <= 1'b0;
      end else if (mode_wr) begin
        mode_req     <= mode_wdata;
        mode_req_int <= mode_wint;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                osc_wait_q <= 1'b0;
    else if (scm_entry)        osc_wait_q <= 1'b1;
    else if (cur_d != M_SCM)   osc_wait_q <= 1'b0;
    else if (osc_stable)       osc_wait_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ref_ok_q <= 1'b0;
    else if (win_end) ref_ok_q <= ~ref_short;
  end

  assign ref_good = mon_disable | (ref_mon & ref_ok_q);

  wire ack = flag_wr1 & arm_q & ~loc_rst_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loss_flag <= 1'b0;
      lock_lost <= 1'b0;
      arm_q     <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      if (loss_evt)  loss_flag <= 1'b1;
      else if (ack)  loss_flag <= 1'b0;
      if (loss_evt && in_lock) lock_lost <= 1'b1;
      else if (ack)            lock_lost <= 1'b0;
      if (flag_wr1)                  arm_q <= 1'b0;
      else if (stat_rd && loss_flag) arm_q <= 1'b1;
      rst_req <= loss_evt & (loc_rst_en | (in_lock & lol_rst_en));
    end
  end

  assign irq = loss_flag & ~loc_rst_en & ~(lock_lost & lol_rst_en);
endmodule

module clkloss_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mon_disable,
  input logic       mode_wr,
  input logic       flag_wr1,
  input logic       loc_rst_en,
  input logic [1:0] mode_req,
  input logic [1:0] mode_cur,
  input logic       mode_cur_int,
  input logic       ref_good,
  input logic       loss_flag,
  input logic       lock_lost,
  input logic       rst_req
);
  p_clear_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loss_flag) |-> ($past(flag_wr1) && !$past(loc_rst_en)));

  p_disable_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_disable && !loss_flag) |=> !loss_flag);

  p_lock_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> loss_flag);

  p_rst_has_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> loss_flag);

  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_cur_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == $past(mode_req)) || (mode_cur == mode_req && loss_flag));

  p_forced_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_req != $past(mode_req)) && !$past(mode_wr))
      |-> ((mode_cur == 2'b01 || mode_cur == 2'b10) && loss_flag && !mode_cur_int));

  p_ref_good_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_good |-> (mon_disable || mode_cur == 2'b10 || (mode_cur == 2'b11 && !mode_cur_int)));
endmodule

bind clkloss_guard clkloss_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mon_disable(mon_disable), .mode_wr(mode_wr),
  .flag_wr1(flag_wr1), .loc_rst_en(loc_rst_en), .mode_req(mode_req),
  .mode_cur(mode_cur), .mode_cur_int(mode_cur_int), .ref_good(ref_good),
  .loss_flag(loss_flag), .lock_lost(lock_lost), .rst_req(rst_req)
);

// File: tb/clkloss_guard_test.sv
module clkloss_guard_test;
  localparam int WIN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk_in = 1'b0, osc_clk_in = 1'b0;
  logic mon_disable = 1'b0, osc_stable = 1'b1;
  logic mode_wr = 1'b0, mode_wint = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic stat_rd = 1'b0, flag_wr1 = 1'b0;
  logic loc_rst_en = 1'b0, lol_rst_en = 1'b0;
  logic [1:0] mode_req, mode_cur;
  logic mode_req_int, mode_cur_int, ref_good, loss_flag, lock_lost, irq, rst_req;

  clkloss_guard #(.WIN_LEN(WIN), .MIN_EDGES(2)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, rst_pulses = 0;
  logic [7:0] ph = '0;
  logic ref_run = 1'b1, osc_run = 1'b1;

  always @(negedge clk) begin
    ph <= ph + 8'd1;
    if (ref_run) ref_clk_in <= ph[2];
    if (osc_run) osc_clk_in <= ph[1];
    if (rst_req) rst_pulses <= rst_pulses + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog act %0d exp %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int code_of(input int m);
    return (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? 2 : 3;
  endfunction

  task automatic run_case(input int mi, input int st, input int k, input int d, input int rc);
    bit kr = k[0], ko = k[1];
    bit refm, oscm, refl, oscl, fl, lk, rs, ir, lc, ll;
    int fin, r0;
    lc = rc[0]; ll = rc[1];
    ref_run = 1'b1; osc_run = 1'b1;
    mon_disable = d[0]; osc_stable = st[0];
    loc_rst_en = lc; lol_rst_en = ll;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1 mode_cur", int'(mode_cur), 0);
    chk("R1 mode_req", int'(mode_req), 0);
    chk("R1 flag", int'(loss_flag), 0);
    chk("R1 lock", int'(lock_lost), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ref_good", int'(ref_good), d);
    mode_wdata = 2'(code_of(mi)); mode_wint = (mi == 4); mode_wr = 1'b1;
    step(1);
    mode_wr = 1'b0;
    chk("R10 req next", int'(mode_req), code_of(mi));
    chk("R10 cur lags", int'(mode_cur), 0);
    step(1);
    chk("R10 cur", int'(mode_cur), code_of(mi));
    chk("R10 cur int", int'(mode_cur_int), int'(mi == 4));
    step(2 * WIN + 4);
    refm = (mi == 2) || (mi == 3);
    oscm = (mi == 1 && st == 1) || (mi == 3) || (mi == 4);
    chk("R2 no loss running", int'(loss_flag), 0);
    chk("R8 ref_good running", int'(ref_good), int'(d || refm));
    r0 = rst_pulses;
    ref_run = !kr; osc_run = !ko;
    step(4 * WIN + 4);
    refl = !d && refm && kr;
    oscl = !d && oscm && ko;
    fin = mi;
    if (mi == 3 && refl) fin = 1;
    else if (mi == 3 && oscl) fin = 2;
    else if (mi == 2 && refl) fin = 1;
    fl = refl || oscl;
    lk = (mi == 3 || mi == 4) && fl;
    rs = fl && (lc || (lk && ll));
    ir = fl && !lc && !(lk && ll);
    chk("R2 R9 loss flag", int'(loss_flag), int'(fl));
    chk("R3 R4 mode_cur", int'(mode_cur), code_of(fin));
    chk("R3 R4 mode_req", int'(mode_req), code_of(fin));
    chk("R3 cur int", int'(mode_cur_int), int'(fin == 4));
    chk("R7 lock_lost", int'(lock_lost), int'(lk));
    chk("R6 R7 irq", int'(irq), int'(ir));
    chk("R6 R7 rst_req seen", int'(rst_pulses != r0), int'(rs));
    chk("R8 ref_good after", int'(ref_good), int'(d || ((fin == 2 || fin == 3) && !kr)));
    ref_run = 1'b1; osc_run = 1'b1;
    step(3 * WIN + 4);
    chk("R5 sticky", int'(loss_flag), int'(fl));
    flag_wr1 = 1'b1; step(1); flag_wr1 = 1'b0;
    step(1);
    chk("R5 wr1 without read", int'(loss_flag), int'(fl));
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    flag_wr1 = 1'b1; step(1); flag_wr1 = 1'b0;
    chk("R5 R6 ack flag", int'(loss_flag), int'(fl && lc));
    chk("R5 ack lock", int'(lock_lost), int'(lk && lc));
  endtask

  initial begin
    for (int mi = 0; mi < 5; mi++)
      for (int st = 0; st < 2; st++) begin
        if (st == 0 && mi != 1) continue;
        for (int k = 0; k < 4; k++)
          for (int d = 0; d < 2; d++)
            for (int rc = 0; rc < 4; rc++)
              run_case(mi, st, k, d, rc);
      end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule